// File: doc/BRIEF.md
# ADC-Feedback DAC Trim Controller

This block drives a two-segment current DAC that has two more bits of resolution than the accuracy the system needs. The DAC has a 14-bit code, and the system needs a 12-bit output. The segments are nonlinear on their own. Their ranges overlap, so the block can close the gap with a measurement loop.

On a start request the block takes a 12-bit target and applies a first guess of the code. It waits a programmable number of cycles for the output to settle, then asks an external ADC for a conversion. The ADC reports in 14-bit code units. The block compares the result with the target and adds the signed error to the code. This repeats until the measured value is within half of one 12-bit step, or until the iteration budget is spent. The last code applied stays on the DAC.

The loop normally settles in two to four passes. A sticky done or fail flag reports the outcome until the next start.

Top module: `dac_trim_ctrl`

## Requirements
- R1: After reset the block is idle: busy, done, fail, dac_strobe and adc_start are 0 and both segment codes are 0.
- R2: A start pulse seen while idle latches the target. The first code applied is the target times 4, that is {target, 2'b00}, and is presented in the cycle after the start pulse.
- R3: The coarse segment output carries code bits 13:6. The fine segment output carries code bits 5:0 in its low bits, and its top two bits are 0. Both segments change only in a cycle where the single shared dac_strobe is high. That strobe is a one-cycle pulse for each code applied.
- R4: adc_start is a one-cycle pulse. It is raised exactly settle_cycles + 2 clock cycles after the dac_strobe of the same pass.
- R5: After adc_done, the loop ends with done = 1 when |4*target − adc_result| ≤ 2, the inclusive tolerance in 14-bit units.
- R6: When the tolerance is missed and passes remain, the next code is code + (4*target − adc_result), saturated to 0..16383.
- R7: After 8 measured passes without convergence (the MAX_ITER default), the block stops with fail = 1. Exactly 8 strobes are issued and the last code stays applied.
- R8: A start pulse while busy is ignored: the target in use and the result are unchanged.
- R9: done and fail are never both high. Each holds until the next accepted start, and busy is high from the cycle after start until the outcome is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a trim run (taken only when idle) |
| target | input | 12 | Desired output in 12-bit units |
| settle_cycles | input | SETTLE_W | Extra settling cycles before each conversion |
| dac_coarse | output | 8 | Coarse segment code (code bits 13:6) |
| dac_fine | output | 8 | Fine segment code (code bits 5:0, top bits 0) |
| dac_strobe | output | 1 | Shared update strobe for both segments |
| adc_start | output | 1 | Conversion request pulse |
| adc_done | input | 1 | Conversion finished, result valid |
| adc_result | input | 14 | Measured output in 14-bit code units |
| busy | output | 1 | Trim run in progress |
| done | output | 1 | Converged within tolerance (sticky) |
| fail | output | 1 | Pass budget exhausted (sticky) |

## Verification
The bench first sweeps hundreds of targets across the full 12-bit range against a modelled DAC that has gain error and offset. This separates one-pass hits, two-to-three-pass convergence, and targets near both ends where the model cannot reach and saturation leads to failure. An ADC stuck at full scale and one stuck at zero drive the code into both saturation limits. They confirm the eight-pass budget and that the last code is held. A pure-offset model with offsets of ±2 and ±3 separates the inclusive tolerance edge from a one-step retrim. One run injects a second start while busy to show it changes nothing.

// File: rtl/dac_trim_pkg.sv
package dac_trim_pkg;
  localparam int TGT_W    = 12;
  localparam int EXTRA_W  = 2;
  localparam int CODE_W   = TGT_W + EXTRA_W;
  localparam int SEG_W    = 8;
  localparam int FINE_W   = CODE_W - SEG_W;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int TOL      = 1 << (EXTRA_W - 1);

  typedef logic signed [CODE_W+1:0] err_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_APPLY, ST_SETTLE, ST_ADC_GO, ST_ADC_WAIT, ST_EVAL
  } trim_state_t;

  // first guess: target expressed in code units
  function automatic logic [CODE_W-1:0] seed_code(input logic [TGT_W-1:0] t);
    return {t, {EXTRA_W{1'b0}}};
  endfunction

  // signed distance from measurement to target, in code units
  function automatic err_t meas_error(input logic [TGT_W-1:0] t,
                                      input logic [CODE_W-1:0] m);
    err_t tv, mv;
    tv = err_t'({2'b00, t, {EXTRA_W{1'b0}}});
    mv = err_t'({2'b00, m});
    return tv - mv;
  endfunction

  function automatic logic in_tol(input logic [TGT_W-1:0] t,
                                  input logic [CODE_W-1:0] m);
    err_t e;
    e = meas_error(t, m);
    return (e <= err_t'(TOL)) && (e >= -err_t'(TOL));
  endfunction

  function automatic logic [CODE_W-1:0] trim_code(input logic [CODE_W-1:0] c,
                                                  input logic [TGT_W-1:0]  t,
                                                  input logic [CODE_W-1:0] m);
    err_t s;
    s = err_t'({2'b00, c}) + meas_error(t, m);
    if (s < 0)                       return '0;
    else if (s > err_t'(CODE_MAX))   return '1;
    else                             return s[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/dac_trim_settle.sv
module dac_trim_settle #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         count_en,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (count_en) cnt_q <= cnt_q + 1'b1;
  end

  assign hit = count_en && (cnt_q == limit);

  AST_SETTLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/dac_trim_split.sv
module dac_trim_split #(
  parameter int CODE_W = 14,
  parameter int SEG_W  = 8,
  parameter int FINE_W = CODE_W - SEG_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [SEG_W-1:0]  coarse,
  output logic [SEG_W-1:0]  fine
);
  assign coarse = code[CODE_W-1 -: SEG_W];

  generate
    if (SEG_W > FINE_W) begin : g_pad
      assign fine = {{(SEG_W-FINE_W){1'b0}}, code[FINE_W-1:0]};
    end else begin : g_full
      assign fine = code[SEG_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/dac_trim_ctrl.sv
module dac_trim_ctrl
  import dac_trim_pkg::*;
#(
  parameter int MAX_ITER = 8,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [TGT_W-1:0]    target,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [SEG_W-1:0]    dac_coarse,
  output logic [SEG_W-1:0]    dac_fine,
  output logic                dac_strobe,
  output logic                adc_start,
  input  logic                adc_done,
  input  logic [CODE_W-1:0]   adc_result,
  output logic                busy,
  output logic                done,
  output logic                fail
);
  localparam int ITER_W = $clog2(MAX_ITER + 1);

  trim_state_t         state_q, state_d;
  logic [TGT_W-1:0]    tgt_q;
  logic [CODE_W-1:0]   code_q, meas_q;
  logic [ITER_W-1:0]   iter_q;
  logic                done_q, fail_q;
  logic                settle_hit;

  // named events
  logic ev_launch, ev_eval, ev_converged, ev_exhausted, ev_retrim;
  assign ev_launch    = (state_q == ST_IDLE) && start;
  assign ev_eval      = (state_q == ST_EVAL);
  assign ev_converged = ev_eval && in_tol(tgt_q, meas_q);
  assign ev_exhausted = ev_eval && !ev_converged && (iter_q == ITER_W'(MAX_ITER));
  assign ev_retrim    = ev_eval && !ev_converged && !ev_exhausted;

  dac_trim_settle #(.W(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (state_q == ST_APPLY),
    .count_en (state_q == ST_SETTLE),
    .limit    (settle_cycles),
    .hit      (settle_hit)
  );

  dac_trim_split #(.CODE_W(CODE_W), .SEG_W(SEG_W), .FINE_W(FINE_W)) u_split (
    .code   (code_q),
    .coarse (dac_coarse),
    .fine   (dac_fine)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start) state_d = ST_APPLY;
      ST_APPLY:    state_d = ST_SETTLE;
      ST_SETTLE:   if (settle_hit) state_d = ST_ADC_GO;
      ST_ADC_GO:   state_d = ST_ADC_WAIT;
      ST_ADC_WAIT: if (adc_done) state_d = ST_EVAL;
      ST_EVAL:     state_d = ev_retrim ? ST_APPLY : ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      code_q  <= '0;
      meas_q  <= '0;
      iter_q  <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_launch) begin
        tgt_q  <= target;
        code_q <= seed_code(target);
        iter_q <= ITER_W'(1);
        done_q <= 1'b0;
        fail_q <= 1'b0;
      end
      if (state_q == ST_ADC_WAIT && adc_done) meas_q <= adc_result;
      if (ev_retrim) begin
        code_q <= trim_code(code_q, tgt_q, meas_q);
        iter_q <= iter_q + 1'b1;
      end
      if (ev_converged) done_q <= 1'b1;
      if (ev_exhausted) fail_q <= 1'b1;
    end
  end

  assign dac_strobe = (state_q == ST_APPLY);
  assign adc_start  = (state_q == ST_ADC_GO);
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign fail       = fail_q;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)); // R9
  AST_ADC_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start); // R4
  AST_STROBE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    dac_strobe |=> !dac_strobe); // R3
  AST_SEG_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dac_coarse) || !$stable(dac_fine)) |-> dac_strobe); // R3
  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    iter_q <= ITER_W'(MAX_ITER)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dac_strobe && !adc_start)); // R9
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(tgt_q)); // R8
endmodule

// File: tb/sim_dac_trim_ctrl.sv
module sim_dac_trim_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] target = '0;
  logic [7:0]  settle_cycles = '0;
  logic [7:0]  dac_coarse, dac_fine;
  logic        dac_strobe, adc_start;
  logic        adc_done = 1'b0;
  logic [13:0] adc_result = '0;
  logic        busy, done, fail;

  int n_vec = 0;
  int n_bad = 0;
  int mode  = 0;  // 0 gain+offset, 1 stuck low, 2 stuck high, 3 pure offset
  int offs  = 0;
  int cycles = 0;

  dac_trim_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .target(target),
    .settle_cycles(settle_cycles), .dac_coarse(dac_coarse), .dac_fine(dac_fine),
    .dac_strobe(dac_strobe), .adc_start(adc_start), .adc_done(adc_done),
    .adc_result(adc_result), .busy(busy), .done(done), .fail(fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic int clamp(input int v);
    if (v < 0) return 0;
    if (v > 16383) return 16383;
    return v;
  endfunction

  function automatic int model(input int c);
    case (mode)
      1: return 0;
      2: return 16383;
      3: return clamp(c + offs);
      default: return clamp(c - c / 32 + 3);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec = n_vec + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_one(input int t, input int settle, input bit poke);
    int c, n, m, e, pend, cyc, sc, nstr, last, gap_bad;
    bit pdone, first_ok;
    // bench prediction
    c = t * 4; n = 1; pdone = 0;
    forever begin
      m = model(c);
      e = t * 4 - m;
      if (e <= 2 && e >= -2) begin pdone = 1; break; end
      if (n == 8) break;
      c = clamp(c + e); n = n + 1;
    end
    settle_cycles = 8'(settle);
    @(negedge clk); start = 1'b1; target = 12'(t);
    @(negedge clk); start = 1'b0;
    pend = 0; cyc = 0; sc = 0; nstr = 0; last = 0; gap_bad = 0; first_ok = 1;
    while (busy && cyc < 3000) begin
      cyc++;
      adc_done = 1'b0;
      if (dac_strobe) begin
        nstr++;
        last = int'({dac_coarse, dac_fine[5:0]});
        if (dac_fine[7:6] != 2'b00) gap_bad++;
        if (nstr == 1 && (cyc != 1 || last != t * 4)) first_ok = 0;
        sc = cyc;
      end
      if (adc_start) begin
        if (cyc - sc != settle + 2) gap_bad++;
        pend = 2;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          adc_done = 1'b1;
          adc_result = 14'(model(last));
        end
      end
      start = 1'b0;
      if (poke && cyc == 6) begin start = 1'b1; target = 12'(t ^ 12'hA5A); end
      @(negedge clk);
    end
    adc_done = 1'b0; start = 1'b0;
    check(first_ok, "R2 first code", last, t * 4);
    check(gap_bad == 0, "R4/R3 strobe-to-conversion timing", gap_bad, 0);
    check(done == pdone && fail == !pdone, poke ? "R8 outcome with ignored start" : "R5/R7 outcome",
          {done, fail}, {pdone, !pdone});
    check(last == c, poke ? "R8 final code" : "R6 final code", last, c);
    check(nstr == n, "R7 pass count", nstr, n);
    check(int'({dac_coarse, dac_fine[5:0]}) == c, "R9 code held after finish", {dac_coarse, dac_fine[5:0]}, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !dac_strobe && !adc_start, "R1 idle flags",
          {busy, done, fail, dac_strobe, adc_start}, 0);
    check(dac_coarse == 0 && dac_fine == 0, "R1 segments", {dac_coarse, dac_fine}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep across the target range with a gain/offset DAC model
    mode = 0;
    for (int t = 0; t < 4096; t += 9) run_one(t, t % 4, 1'b0);
    run_one(4095, 2, 1'b0);

    // R7 saturation high and low
    mode = 1; run_one(4095, 1, 1'b0);
    mode = 2; run_one(0, 0, 1'b0);
    mode = 1; run_one(1, 5, 1'b0);

    // R5 tolerance edges
    mode = 3;
    offs = 2;  run_one(1000, 0, 1'b0);
    offs = -2; run_one(1000, 1, 1'b0);
    offs = 3;  run_one(1000, 2, 1'b0);
    offs = -3; run_one(1000, 3, 1'b0);
    offs = 40; run_one(2000, 3, 1'b0);

    // R8 start while busy
    mode = 0; run_one(1234, 3, 1'b1);
    mode = 1; run_one(3000, 2, 1'b1);

    // R9 flags clear on a new start
    mode = 3; offs = 0;
    @(negedge clk); start = 1'b1; target = 12'd50;
    @(negedge clk); start = 1'b0;
    check(busy && !done && !fail, "R9 flags cleared on start", {busy, done, fail}, 4);
    while (busy) begin
      if (adc_start) begin
        @(negedge clk); @(negedge clk);
        adc_done = 1'b1; adc_result = 14'd200;
        @(negedge clk); adc_done = 1'b0;
      end else @(negedge clk);
    end
    check(done && !fail, "R9 done after clean run", {done, fail}, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule